// File: doc/BRIEF.md
# Port-Enable Control Register Bank

This block is the control register bank of a serial service-interface master. Software reaches it over a simple single-cycle register bus that carries a byte address, write data, a write strobe and a read strobe. Read data comes back one cycle later. The bank holds two 32-bit port-enable words. The first covers ports 0 to 31 and the second covers ports 32 to 63. Each word can be loaded whole. It can also be edited bit by bit through a set alias address and a clear alias address, so a driver can switch single ports on or off without a read-modify-write.

Most of the other in-range words are plain storage. There are three exceptions:
- A read-only version word.
- A register whose writes are accepted and discarded.
- A command register that returns the whole bank to its reset values.

Accesses beyond the last word are dropped.

Top module: `portEnableRegs`

## Requirements
- R1: The word index is the byte address with its two low bits dropped. Byte addresses 0x100 and 0x103 reach the same word.
- R2: A write to 0x010 loads enable word 0 with the write data. A write to 0x014 loads enable word 1.
- R3: A write to 0x018 ORs the write data into enable word 0. A write to 0x01C ORs it into enable word 1.
- R4: A write to 0x020 clears every bit of enable word 0 that is 1 in the write data. A write to 0x024 does the same for enable word 1.
- R5: A write to a set or clear alias changes only its own enable word. The words stored at 0x018 to 0x024 read as zero, because no write ever updates them.
- R6: A write to 0x0D0 has no effect, and that word keeps reading zero.
- R7: After reset every word reads zero, except word 0x074, which reads 0xE0050101. Writes to 0x074 are ignored.
- R8: With the 12-bit default address, a read at byte address 0x200 or above returns zero. A write there changes nothing, including the in-range word with the same low index bits.
- R9: A write to any other in-range word stores the data unchanged, and a later read returns it.
- R10: A write to 0x1D0 with bit 31 set, or with bit 30 set, restores every word to its reset value on the next clock edge. A write there with neither bit set does nothing. Word 0x1D0 always reads zero.
- R11: Read data appears on the cycle after the read strobe and holds until the next read. It is zero after an external reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | ADDR_W (12) | Byte address |
| busWrData | input | DATA_W (32) | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per access |
| busRdEn | input | 1 | Read strobe, one cycle per access |
| busRdData | output | DATA_W (32) | Read data, valid the cycle after the read strobe |

## Verification
The hardest state to reach is a bank full of non-reset values just before a reset command. It has to be proven that the command clears every word: both enable words, ordinary storage and the restored version word.

The stimulus first fills the enable words through direct loads and alias edits, and writes generic words. Only then does it issue the command, once with each trigger bit. A write to the command word with neither bit set comes earlier and must leave everything intact. A write at an out-of-range address whose low index bits alias word 0 checks that dropped accesses never wrap into the bank.

// File: rtl/penRegsPkg.sv
package penRegsPkg;
  // Word indices, which the behaviour depends on.
  localparam int NUM_EN    = 2;    // number of port-enable words
  localparam int EN_BASE   = 4;    // byte 0x010
  localparam int SET_BASE  = 6;    // byte 0x018
  localparam int CLR_BASE  = 8;    // byte 0x020
  localparam int VER_WORD  = 29;   // byte 0x074
  localparam int DROP_WORD = 52;   // byte 0x0D0
  localparam int CMD_WORD  = 116;  // byte 0x1D0
  localparam int CMD_BIT_A = 31;
  localparam int CMD_BIT_B = 30;

  typedef struct packed {
    logic              plainWr;
    logic [NUM_EN-1:0] setWord;
    logic [NUM_EN-1:0] clrWord;
    logic              bankReset;
    logic              rdStrobe;
    logic              inRange;
  } ctrlStrb_t;
endpackage

// File: rtl/penRegsCtrl.sv
module penRegsCtrl
  import penRegsPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 128,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int FULL_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctrlStrb_t         strb,
  output logic [IDX_W-1:0]  wordIdx
);
  logic [FULL_W-1:0] fullIdx;
  logic              inRange;

  assign fullIdx = busAddr[ADDR_W-1:2];
  assign inRange = fullIdx < FULL_W'(NUM_WORDS);
  assign wordIdx = fullIdx[IDX_W-1:0];

  always_comb begin
    strb          = '0;
    strb.inRange  = inRange;
    strb.rdStrobe = busRdEn;
    if (busWrEn && inRange) begin
      if (wordIdx == IDX_W'(CMD_WORD)) begin
        strb.bankReset = busWrData[CMD_BIT_A] | busWrData[CMD_BIT_B];
      end else if (wordIdx != IDX_W'(VER_WORD) && wordIdx != IDX_W'(DROP_WORD)) begin
        strb.plainWr = 1'b1;
        for (int k = 0; k < NUM_EN; k++) begin
          if (wordIdx == IDX_W'(SET_BASE + k)) begin
            strb.setWord[k] = 1'b1;
            strb.plainWr    = 1'b0;
          end
          if (wordIdx == IDX_W'(CLR_BASE + k)) begin
            strb.clrWord[k] = 1'b1;
            strb.plainWr    = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/penRegsData.sv
module penRegsData
  import penRegsPkg::*;
#(
  parameter int          DATA_W        = 32,
  parameter int          NUM_WORDS     = 128,
  parameter logic [31:0] VERSION_VALUE = 32'hE005_0101,
  localparam int         IDX_W         = $clog2(NUM_WORDS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  ctrlStrb_t                     strb,
  input  logic [IDX_W-1:0]              wordIdx,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_EN-1:0][DATA_W-1:0] enWords
);
  logic [DATA_W-1:0] bank [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (rst || strb.bankReset) begin
      for (int i = 0; i < NUM_WORDS; i++)
        bank[i] <= (i == VER_WORD) ? DATA_W'(VERSION_VALUE) : '0;
    end else begin
      if (strb.plainWr) bank[wordIdx] <= wrData;
      for (int k = 0; k < NUM_EN; k++) begin
        if (strb.setWord[k])
          bank[EN_BASE + k] <= bank[EN_BASE + k] | wrData;
        else if (strb.clrWord[k])
          bank[EN_BASE + k] <= bank[EN_BASE + k] & ~wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rdData <= '0;
    else if (strb.rdStrobe) rdData <= strb.inRange ? bank[wordIdx] : '0;
  end

  for (genvar g = 0; g < NUM_EN; g++) begin : gEnOut
    assign enWords[g] = bank[EN_BASE + g];
  end
endmodule

// File: rtl/portEnableRegs.sv
module portEnableRegs
  import penRegsPkg::*;
#(
  parameter int          ADDR_W        = 12,
  parameter int          DATA_W        = 32,
  parameter int          NUM_WORDS     = 128,
  parameter logic [31:0] VERSION_VALUE = 32'hE005_0101,
  localparam int         IDX_W         = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData
);
  ctrlStrb_t                     strb;
  logic [IDX_W-1:0]              wordIdx;
  logic [NUM_EN-1:0][DATA_W-1:0] enWords;

  penRegsCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) ctrl (
    .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strb(strb), .wordIdx(wordIdx)
  );

  penRegsData #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .VERSION_VALUE(VERSION_VALUE)) data (
    .clk(clk), .rst(rst), .strb(strb), .wordIdx(wordIdx),
    .wrData(busWrData), .rdData(busRdData), .enWords(enWords)
  );
endmodule

// File: rtl/penRegsChecker.sv
module penRegsChecker
  import penRegsPkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 128,
  localparam int FULL_W   = ADDR_W - 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic [ADDR_W-1:0]             busAddr,
  input logic [DATA_W-1:0]             busWrData,
  input logic                          busWrEn,
  input logic                          busRdEn,
  input logic [DATA_W-1:0]             busRdData,
  input logic [NUM_EN-1:0][DATA_W-1:0] enWords
);
  logic [FULL_W-1:0] idx;
  assign idx = busAddr[ADDR_W-1:2];

  assert_direct_load_R2: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && idx == FULL_W'(EN_BASE)) |=> enWords[0] == $past(busWrData));

  assert_set_alias_R3: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && idx == FULL_W'(SET_BASE)) |=>
      enWords[0] == ($past(enWords[0]) | $past(busWrData)));

  assert_clr_alias_R4: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && idx == FULL_W'(CLR_BASE + 1)) |=>
      enWords[1] == ($past(enWords[1]) & ~$past(busWrData)));

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (rst)
    !busWrEn |=> $stable(enWords));

  assert_oob_read_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && idx >= FULL_W'(NUM_WORDS)) |=> busRdData == '0);

  assert_cmd_reset_R10: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && idx == FULL_W'(CMD_WORD) && (busWrData[CMD_BIT_A] || busWrData[CMD_BIT_B]))
      |=> enWords == '0);

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !busRdEn |=> $stable(busRdData));
endmodule

bind portEnableRegs penRegsChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busRdData(busRdData), .enWords(enWords)
);

// File: tb/portEnableRegs_test.sv
module portEnableRegs_test;
  localparam int          NV  = 27;
  localparam logic [31:0] VER = 32'hE005_0101;

  // Vector layout: {requirement[3:0], isRead, byteAddr[11:0], data or expected[31:0]}
  localparam logic [48:0] VEC [NV] = '{
    {4'd7,  1'b1, 12'h074, VER},           // R7 version word
    {4'd7,  1'b1, 12'h010, 32'h0},         // R7 enable word 0 zero
    {4'd2,  1'b0, 12'h010, 32'h0000_00F0},
    {4'd2,  1'b1, 12'h010, 32'h0000_00F0}, // R2
    {4'd3,  1'b0, 12'h018, 32'h0000_0F01},
    {4'd3,  1'b1, 12'h010, 32'h0000_0FF1}, // R3
    {4'd5,  1'b1, 12'h018, 32'h0},         // R5 alias storage untouched
    {4'd4,  1'b0, 12'h020, 32'h0000_00F1},
    {4'd4,  1'b1, 12'h010, 32'h0000_0F00}, // R4
    {4'd2,  1'b0, 12'h014, 32'hAAAA_5555},
    {4'd2,  1'b1, 12'h014, 32'hAAAA_5555}, // R2 word 1
    {4'd3,  1'b0, 12'h01C, 32'h0000_AAAA},
    {4'd3,  1'b1, 12'h014, 32'hAAAA_FFFF}, // R3 word 1
    {4'd4,  1'b0, 12'h024, 32'hAAAA_0000},
    {4'd4,  1'b1, 12'h014, 32'h0000_FFFF}, // R4 word 1
    {4'd5,  1'b1, 12'h010, 32'h0000_0F00}, // R5 word 0 untouched
    {4'd9,  1'b0, 12'h100, 32'hDEAD_BEEF},
    {4'd9,  1'b1, 12'h100, 32'hDEAD_BEEF}, // R9
    {4'd1,  1'b1, 12'h103, 32'hDEAD_BEEF}, // R1 low bits ignored
    {4'd6,  1'b0, 12'h0D0, 32'h0000_1234},
    {4'd6,  1'b1, 12'h0D0, 32'h0},         // R6
    {4'd7,  1'b0, 12'h074, 32'h0},
    {4'd7,  1'b1, 12'h074, VER},           // R7 read-only
    {4'd10, 1'b0, 12'h1D0, 32'h3FFF_FFFF},
    {4'd10, 1'b1, 12'h010, 32'h0000_0F00}, // R10 no trigger bit
    {4'd8,  1'b0, 12'h800, 32'h5A5A_5A5A},
    {4'd8,  1'b1, 12'h800, 32'h0}          // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  int          nChecks = 0;
  int          nFails  = 0;
  logic        done = 1'b0;

  always #5 clk = ~clk;

  portEnableRegs uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busReadCheck(input int req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    check(req, busRdData, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(11, busRdData, 32'h0);               // R11 reset state

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][44]) busReadCheck(int'(VEC[v][48:45]), VEC[v][43:32], VEC[v][31:0]);
      else            busWrite(VEC[v][43:32], VEC[v][31:0]);
    end

    busReadCheck(8, 12'h000, 32'h0);           // R8 no wrap into word 0
    busReadCheck(10, 12'h1D0, 32'h0);          // R10 command word reads zero
    repeat (2) @(negedge clk);
    check(11, busRdData, 32'h0);               // R11 holds last read

    busWrite(12'h1D0, 32'h8000_0000);          // R10 trigger bit 31
    busReadCheck(10, 12'h010, 32'h0);
    busReadCheck(10, 12'h014, 32'h0);
    busReadCheck(10, 12'h100, 32'h0);
    busReadCheck(10, 12'h074, VER);

    busWrite(12'h018, 32'h0000_0003);
    busWrite(12'h040, 32'h1111_2222);
    busWrite(12'h1D0, 32'h4000_0000);          // R10 trigger bit 30
    busReadCheck(10, 12'h010, 32'h0);
    busReadCheck(10, 12'h040, 32'h0);

    busWrite(12'h1FC, 32'hCAFE_F00D);
    busReadCheck(9, 12'h1FC, 32'hCAFE_F00D);   // R9 last in-range word
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(11, busRdData, 32'h0);               // R11 external reset clears read data
    busReadCheck(7, 12'h1FC, 32'h0);           // R7
    busReadCheck(7, 12'h074, VER);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R11: watchdog expired, actual running expected done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule